// File: doc/BRIEF.md
# Per-Group Command Source Arbiter

This block sits in front of the control registers of one 32-pin bank, split into four 8-pin groups. Three masters can issue writes to that register space: the main processor, an LPC host and a coprocessor. Each group has an owner, held as a 2-bit code. A write to a gated control register goes through only for the groups that the issuing master owns. It is passed on one cycle later with a per-group enable vector, so a group the master does not own is left untouched.

Ownership is held in two command-source registers. One holds the low bit of every group's code and the other holds the high bit. Only the main processor may write them. Debounce select and debounce timer registers are exempt from the gating. Any master may write them, and all four group enables are set. Code 3 is reserved. If both bits of a group are ever set, a sticky error flag rises and the group is treated as owned by the main processor. For this reason software moves a group between the main processor and the coprocessor by writing the high-bit register first. Moving a group directly between the LPC host and the coprocessor forms code 3, so software must route that change through the main processor.

Top module: `cmd_source_arbiter`

## Requirements
- R1: After reset every group's effective owner is 0 (main processor), `rsvd_err_o` is 0 and `fwd_valid_o` is 0.
- R2: A write to a gated address is forwarded on the clock edge that samples it. `fwd_grp_en_o[g]` is 1 exactly for the groups whose effective owner equals `req_master_i`, and address and data are copied unchanged. Master codes are 0 main, 1 LPC host, 2 coprocessor.
- R3: A gated write from a master that owns no group, including master code 3, is dropped. `fwd_valid_o` stays 0 and all group enables stay 0.
- R4: The ownership registers sit at `CMD_BASE` (low code bit) and `CMD_BASE+4` (high code bit). Group g's code is {high[8g], low[8g]}, and `owner_o[2g+1:2g]` shows it. Only master 0 may write these registers; a write from any other master leaves all codes unchanged. Bits other than 8g are ignored. A change shows on `owner_o` one cycle after the write.
- R5: Writes to either ownership register are never forwarded, whoever issues them.
- R6: If any group's code becomes 3, `rsvd_err_o` rises on the same edge and stays 1 until reset. That group's effective owner reads 0 and it is gated as a main-processor group.
- R7: Writes to `DBNC_BASE..DBNC_BASE+DBNC_SPAN-1` and `TMR_BASE..TMR_BASE+TMR_SPAN-1` (defaults 0x040–0x047 and 0x050–0x05B) are forwarded from any master with all four enables set. The addresses just outside these ranges are gated.
- R8: Moving a group from 0 to 2, or from 2 to 0, by writing the high-bit register before the low-bit register never raises `rsvd_err_o`. The intermediate owner is visible between the two writes.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Write request strobe |
| req_master_i | input | 2 | Issuing master code |
| req_addr_i | input | AW (9) | Register byte address within the bank space |
| req_wdata_i | input | DW (32) | Write data |
| fwd_valid_o | output | 1 | Forwarded write strobe |
| fwd_addr_o | output | AW (9) | Forwarded address |
| fwd_wdata_o | output | DW (32) | Forwarded data |
| fwd_grp_en_o | output | GROUPS (4) | Per-group write enable of the forwarded write |
| owner_o | output | 2*GROUPS (8) | Effective owner code per group |
| rsvd_err_o | output | 1 | Sticky reserved-code error |

## Verification
Some properties are checked on every cycle. A forwarded gated write never enables a group owned by another master. An exempt write always enables all groups. Ownership writes never reach the downstream side. A non-main write never changes ownership. The error flag never falls, and a stored code 3 always has the flag raised. The bench's scenarios cover the rest:
- every owner assignment over the three legal codes, crossed with each master;
- the address boundaries of the exempt ranges;
- the ignored bits of the ownership registers;
- the write-ordering transitions;
- the effect of a reserved code on gating and its clearing by reset.

// File: rtl/cmdsrc_pkg.sv
package cmdsrc_pkg;
  typedef enum logic [1:0] {
    MST_MAIN = 2'd0,
    MST_LPC  = 2'd1,
    MST_COP  = 2'd2,
    MST_RSVD = 2'd3
  } master_e;

  typedef enum logic [1:0] {
    CLS_GATED  = 2'd0,
    CLS_EXEMPT = 2'd1,
    CLS_SRC0   = 2'd2,
    CLS_SRC1   = 2'd3
  } acls_e;
endpackage

// File: rtl/csa_decode.sv
module csa_decode
  import cmdsrc_pkg::*;
#(
  parameter int AW        = 9,
  parameter int CMD_BASE  = 'h060,
  parameter int DBNC_BASE = 'h040,
  parameter int DBNC_SPAN = 8,
  parameter int TMR_BASE  = 'h050,
  parameter int TMR_SPAN  = 12
) (
  input  logic [AW-1:0] addr_i,
  output acls_e         cls_o
);
  localparam logic [31:0] SRC0_A = 32'(CMD_BASE);
  localparam logic [31:0] SRC1_A = 32'(CMD_BASE + 4);
  localparam logic [31:0] DB_LO  = 32'(DBNC_BASE);
  localparam logic [31:0] DB_HI  = 32'(DBNC_BASE + DBNC_SPAN);
  localparam logic [31:0] TM_LO  = 32'(TMR_BASE);
  localparam logic [31:0] TM_HI  = 32'(TMR_BASE + TMR_SPAN);

  logic [31:0] a;
  logic        in_db, in_tm;

  always_comb begin
    a     = 32'(addr_i);
    in_db = (a >= DB_LO) && (a < DB_HI);
    in_tm = (a >= TM_LO) && (a < TM_HI);
    if (a == SRC0_A)             cls_o = CLS_SRC0;
    else if (a == SRC1_A)        cls_o = CLS_SRC1;
    else if (in_db || in_tm)     cls_o = CLS_EXEMPT;
    else                         cls_o = CLS_GATED;
  end
endmodule

// File: rtl/csa_owner_regs.sv
module csa_owner_regs
  import cmdsrc_pkg::*;
#(
  parameter  int GROUPS = 4,
  parameter  int GRP_W  = 8,
  localparam int DW     = GROUPS * GRP_W,
  localparam int OW     = 2 * GROUPS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          sel1_i,
  input  logic [1:0]    master_i,
  input  logic [DW-1:0] wdata_i,
  output logic [OW-1:0] owner_o,
  output logic          err_o
);
  logic [GROUPS-1:0] s0_q, s1_q, s0_d, s1_d, pick;
  logic              wr_ok, err_q;

  assign wr_ok = we_i && (master_i == MST_MAIN);

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    assign pick[g] = wdata_i[g*GRP_W];
    // reserved code falls back to main ownership
    assign owner_o[2*g +: 2] = (s1_q[g] && s0_q[g]) ? 2'b00 : {s1_q[g], s0_q[g]};
  end

  always_comb begin
    s0_d = (wr_ok && !sel1_i) ? pick : s0_q;
    s1_d = (wr_ok &&  sel1_i) ? pick : s1_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s0_q  <= '0;
      s1_q  <= '0;
      err_q <= 1'b0;
    end else begin
      s0_q  <= s0_d;
      s1_q  <= s1_d;
      err_q <= err_q | (|(s0_d & s1_d));
    end
  end

  assign err_o = err_q;

  AST_SRC_MAIN_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(we_i && (master_i != MST_MAIN)) |-> ($stable(s0_q) && $stable(s1_q))); // R4

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R6

  AST_RSVD_FLAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((s0_q & s1_q) != '0) |-> err_o); // R6
endmodule

// File: rtl/csa_grant.sv
module csa_grant
  import cmdsrc_pkg::*;
#(
  parameter  int GROUPS = 4,
  localparam int OW     = 2 * GROUPS
) (
  input  logic              valid_i,
  input  acls_e             cls_i,
  input  logic [1:0]        master_i,
  input  logic [OW-1:0]     owner_i,
  output logic [GROUPS-1:0] en_o,
  output logic              fwd_o
);
  for (genvar g = 0; g < GROUPS; g++) begin : g_en
    assign en_o[g] = valid_i &&
                     ((cls_i == CLS_EXEMPT) ||
                      ((cls_i == CLS_GATED) && (owner_i[2*g +: 2] == master_i)));
  end
  assign fwd_o = |en_o;
endmodule

// File: rtl/cmd_source_arbiter.sv
module cmd_source_arbiter
  import cmdsrc_pkg::*;
#(
  parameter  int GROUPS    = 4,
  parameter  int GRP_W     = 8,
  parameter  int AW        = 9,
  parameter  int CMD_BASE  = 'h060,
  parameter  int DBNC_BASE = 'h040,
  parameter  int DBNC_SPAN = 8,
  parameter  int TMR_BASE  = 'h050,
  parameter  int TMR_SPAN  = 12,
  localparam int DW        = GROUPS * GRP_W,
  localparam int OW        = 2 * GROUPS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_master_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [DW-1:0]     req_wdata_i,
  output logic              fwd_valid_o,
  output logic [AW-1:0]     fwd_addr_o,
  output logic [DW-1:0]     fwd_wdata_o,
  output logic [GROUPS-1:0] fwd_grp_en_o,
  output logic [OW-1:0]     owner_o,
  output logic              rsvd_err_o
);
  acls_e             cls;
  logic [GROUPS-1:0] en;
  logic              fwd, src_we;

  logic              valid_q;
  logic [AW-1:0]     addr_q;
  logic [DW-1:0]     data_q;
  logic [GROUPS-1:0] en_q;

  csa_decode #(
    .AW(AW), .CMD_BASE(CMD_BASE), .DBNC_BASE(DBNC_BASE), .DBNC_SPAN(DBNC_SPAN),
    .TMR_BASE(TMR_BASE), .TMR_SPAN(TMR_SPAN)
  ) u_dec (
    .addr_i(req_addr_i),
    .cls_o (cls)
  );

  assign src_we = req_valid_i && ((cls == CLS_SRC0) || (cls == CLS_SRC1));

  csa_owner_regs #(.GROUPS(GROUPS), .GRP_W(GRP_W)) u_own (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (src_we),
    .sel1_i  (cls == CLS_SRC1),
    .master_i(req_master_i),
    .wdata_i (req_wdata_i),
    .owner_o (owner_o),
    .err_o   (rsvd_err_o)
  );

  csa_grant #(.GROUPS(GROUPS)) u_gnt (
    .valid_i (req_valid_i),
    .cls_i   (cls),
    .master_i(req_master_i),
    .owner_i (owner_o),
    .en_o    (en),
    .fwd_o   (fwd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      en_q    <= '0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      valid_q <= fwd;
      en_q    <= en;
      if (fwd) begin
        addr_q <= req_addr_i;
        data_q <= req_wdata_i;
      end
    end
  end

  assign fwd_valid_o  = valid_q;
  assign fwd_addr_o   = addr_q;
  assign fwd_wdata_o  = data_q;
  assign fwd_grp_en_o = en_q;

  AST_FWD_NOT_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_valid_o |-> ((32'(fwd_addr_o) != 32'(CMD_BASE)) &&
                     (32'(fwd_addr_o) != 32'(CMD_BASE + 4)))); // R5

  AST_QUIET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fwd_valid_o |-> (fwd_grp_en_o == '0)); // R3

  AST_EXEMPT_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(req_valid_i && (cls == CLS_EXEMPT)) |-> (fwd_valid_o && (&fwd_grp_en_o))); // R7

  for (genvar g = 0; g < GROUPS; g++) begin : g_chk
    AST_EN_OWNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fwd_grp_en_o[g] && ($past(cls) == CLS_GATED)) |->
        ($past(owner_o[2*g +: 2]) == $past(req_master_i))); // R2
  end
endmodule

// File: tb/sim_cmd_source_arbiter.sv
module sim_cmd_source_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int G = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [1:0]  req_master_i = '0;
  logic [8:0]  req_addr_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic        fwd_valid_o;
  logic [8:0]  fwd_addr_o;
  logic [31:0] fwd_wdata_o;
  logic [3:0]  fwd_grp_en_o;
  logic [7:0]  owner_o;
  logic        rsvd_err_o;

  int tests = 0;
  int fails = 0;
  logic [3:0] m_s0 = '0, m_s1 = '0;
  int cfg [G];

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_source_arbiter u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_master_i(req_master_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i), .fwd_valid_o(fwd_valid_o),
    .fwd_addr_o(fwd_addr_o), .fwd_wdata_o(fwd_wdata_o), .fwd_grp_en_o(fwd_grp_en_o),
    .owner_o(owner_o), .rsvd_err_o(rsvd_err_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // bit 8g carries group g; all other bits set to prove they are ignored
  function automatic logic [31:0] spread(logic [3:0] b);
    logic [31:0] d = 32'hFEFE_FEFE;
    for (int g = 0; g < G; g++) d[8*g] = b[g];
    return d;
  endfunction

  function automatic logic [7:0] exp_owner();
    logic [7:0] e;
    for (int g = 0; g < G; g++)
      e[2*g +: 2] = (m_s1[g] && m_s0[g]) ? 2'b00 : {m_s1[g], m_s0[g]};
    return e;
  endfunction

  function automatic logic [3:0] exp_en(logic [1:0] m);
    logic [7:0] e = exp_owner();
    logic [3:0] r;
    for (int g = 0; g < G; g++) r[g] = (e[2*g +: 2] == m);
    return r;
  endfunction

  task automatic wr(logic [1:0] m, logic [8:0] a, logic [31:0] d);
    @(negedge clk);
    req_valid_i  = 1'b1;
    req_master_i = m;
    req_addr_i   = a;
    req_wdata_i  = d;
    @(negedge clk);
    req_valid_i  = 1'b0;
  endtask

  task automatic wr_src(bit hi, logic [3:0] b);
    wr(2'd0, hi ? 9'h064 : 9'h060, spread(b));
    if (hi) m_s1 = b; else m_s0 = b;
    chk("R5 src write not forwarded", 32'(fwd_valid_o), 32'd0);
  endtask

  task automatic gated(logic [1:0] m, logic [8:0] a, logic [31:0] d);
    logic [3:0] e;
    e = exp_en(m);
    wr(m, a, d);
    if (e == 4'd0) begin
      chk("R3 valid", 32'(fwd_valid_o), 32'd0);
      chk("R3 en", 32'(fwd_grp_en_o), 32'd0);
    end else begin
      chk("R2 valid", 32'(fwd_valid_o), 32'd1);
      chk("R2 en", 32'(fwd_grp_en_o), 32'(e));
      chk("R2 addr", 32'(fwd_addr_o), 32'(a));
      chk("R2 data", fwd_wdata_o, d);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [8:0] gl [4];
    logic [3:0] n0, n1;
    gl[0] = 9'h000; gl[1] = 9'h048; gl[2] = 9'h05C; gl[3] = 9'h1FC;

    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 owner", 32'(owner_o), 32'd0);
    chk("R1 err", 32'(rsvd_err_o), 32'd0);
    chk("R1 valid", 32'(fwd_valid_o), 32'd0);

    // every legal owner assignment, crossed with every master code
    for (int c = 0; c < 81; c++) begin
      int t = c;
      for (int g = 0; g < G; g++) begin cfg[g] = t % 3; t = t / 3; end
      for (int g = 0; g < G; g++) begin n0[g] = (cfg[g] == 1); n1[g] = (cfg[g] == 2); end
      wr_src(1'b0, m_s0 & n0);
      wr_src(1'b1, n1);
      wr_src(1'b0, n0);
      chk("R4 owner", 32'(owner_o), 32'(exp_owner()));
      chk("R6 no err on legal codes", 32'(rsvd_err_o), 32'd0);
      for (int m = 0; m < 4; m++)
        gated(2'(m), gl[(c + m) % 4], {8'(c), 8'(m), 16'hA5C3});
    end

    // non-main writes to ownership registers: ignored and not forwarded
    wr_src(1'b0, 4'b0000);
    wr_src(1'b1, 4'b0000);
    for (int m = 1; m < 4; m++) begin
      wr(2'(m), 9'h060, 32'hFFFF_FFFF);
      chk("R5 non-main src0", 32'(fwd_valid_o), 32'd0);
      wr(2'(m), 9'h064, 32'hFFFF_FFFF);
      chk("R5 non-main src1", 32'(fwd_valid_o), 32'd0);
      chk("R4 non-main ignored", 32'(owner_o), 32'd0);
    end

    // exempt ranges and their edges
    wr_src(1'b1, 4'b0101);
    for (int m = 0; m < 4; m++) begin
      wr(2'(m), 9'h040, 32'h1111_0000 + 32'(m));
      chk("R7 dbnc lo en", 32'(fwd_grp_en_o), 32'hF);
      chk("R7 dbnc lo data", fwd_wdata_o, 32'h1111_0000 + 32'(m));
      wr(2'(m), 9'h044, 32'h2);
      chk("R7 dbnc hi en", 32'(fwd_grp_en_o), 32'hF);
      wr(2'(m), 9'h050, 32'h3);
      chk("R7 tmr lo en", 32'(fwd_grp_en_o), 32'hF);
      wr(2'(m), 9'h058, 32'h4);
      chk("R7 tmr hi en", 32'(fwd_grp_en_o), 32'hF);
      gated(2'(m), 9'h048, 32'h5);
      gated(2'(m), 9'h05C, 32'h6);
      gated(2'(m), 9'h03C, 32'h7);
    end

    // ordering 0 -> 2 -> 0, high bit first
    wr_src(1'b1, 4'b0000);
    wr_src(1'b1, 4'b0001);
    chk("R8 to cop intermediate", 32'(owner_o), 32'h02);
    wr_src(1'b0, 4'b0000);
    chk("R8 to cop no err", 32'(rsvd_err_o), 32'd0);
    wr_src(1'b1, 4'b0000);
    chk("R8 back intermediate", 32'(owner_o), 32'h00);
    wr_src(1'b0, 4'b0000);
    chk("R8 back no err", 32'(rsvd_err_o), 32'd0);

    // reserved code on group 0
    wr_src(1'b0, 4'b0001);
    chk("R6 pre err", 32'(rsvd_err_o), 32'd0);
    wr_src(1'b1, 4'b0001);
    chk("R6 err raised", 32'(rsvd_err_o), 32'd1);
    chk("R6 owner falls back", 32'(owner_o), 32'h00);
    gated(2'd1, 9'h000, 32'hDEAD_0001);
    gated(2'd0, 9'h000, 32'hDEAD_0000);
    wr_src(1'b1, 4'b0000);
    wr_src(1'b0, 4'b0000);
    chk("R6 err sticky", 32'(rsvd_err_o), 32'd1);

    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    m_s0 = '0; m_s1 = '0;
    @(negedge clk);
    chk("R1 err after reset", 32'(rsvd_err_o), 32'd0);
    chk("R1 owner after reset", 32'(owner_o), 32'd0);
    gated(2'd0, 9'h100, 32'h0BAD_F00D);

    finish_run();
  end
endmodule